// File: doc/BRIEF.md
# SD Card Single-Line Block Receiver

This block is the receive side of the data path in an SD/MMC host. It watches the card's data line 0 in the card clock domain. It waits for a start bit and shifts in one block of data, most significant bit first within each byte. It then takes the 16-bit CRC that follows the data and the end bit, and checks both. Received bytes are packed into words and written to a small receive FIFO, which a DMA engine drains through a request/read pair.

Software programs the path through a handful of configuration inputs:

- an enable,
- a direction select (card to host),
- a DMA enable,
- the block length, given as a power-of-two exponent of the byte count,
- the total transfer length in bytes.

Outcomes are reported as four sticky status bits. Each bit is cleared by a write strobe with a per-bit mask. A transfer can span several blocks. Between blocks the path rearms for the next start bit, and it parks once the programmed length has been reached.

Top module: `sd_rx_datapath`

## Requirements
- R1: After reset, `status` is 0, `busy` is 0 and `dma_req` is 0.
- R2: The path runs only while both `cfg_en` and `cfg_dir_rx` are 1. Otherwise it stays idle and ignores the data line, so no flags are set and no words are written. Clearing either input mid-block returns the path to idle and discards the partial word.
- R3: The block length in bytes is 2^`cfg_blk_exp`. The exponent is clamped into the range 2 to MAX_EXP, so a value of 1 behaves as 2. The default MAX_EXP of 11 admits 9, which gives 512-byte blocks.
- R4: Once armed, the path waits for a 0 on `dat0`. It then samples 8·2^exp data bits, MSB first per byte, followed by 16 CRC bits (MSB first) and one end bit, taking one bit per rising clock edge.
- R5: The CRC is CRC16 with generator 0x1021 and a zero start value, computed over the data bits. When it equals the received CRC and the end bit is 1, status bit 0 (block done) is set.
- R6: When the CRC differs or the end bit is 0, status bit 2 (CRC error) is set instead of bit 0. The block's words remain in the FIFO.
- R7: At each end bit, if the bytes received since enable are at least `cfg_data_len`, status bit 1 (transfer done) is set in the same cycle. The path then parks (`busy` low) and ignores further start bits until it is disabled.
- R8: When the length is not yet reached, the path returns to waiting for a start bit after the end bit, with `busy` still high.
- R9: Bytes are packed little-endian: within each group of four received bytes, the first lands in `fifo_rdata[7:0]`.
- R10: If a word completes while the FIFO is full, the word is dropped and status bit 3 (overrun) is set.
- R11: `dma_req` is high exactly when `cfg_dma_en` is 1 and the FIFO holds a word. `fifo_rdata` shows the oldest word, and `fifo_rd` while `dma_req` is high removes it.
- R12: Status bits stay set until `clr_we` is pulsed with the matching `clr_mask` bit at 1. Bits whose mask bit is 0 are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; the data line is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dat0 | input | 1 | Card data line 0 |
| cfg_en | input | 1 | Data path enable |
| cfg_dir_rx | input | 1 | 1 selects card-to-host transfer |
| cfg_dma_en | input | 1 | Lets the DMA side see and read the FIFO |
| cfg_blk_exp | input | EXP_W (4) | Block length exponent |
| cfg_data_len | input | LEN_W (16) | Total transfer length in bytes |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 4 | Bits of status to clear |
| status | output | 4 | Sticky flags: 0 block done, 1 transfer done, 2 CRC error, 3 overrun |
| busy | output | 1 | High while armed and not parked |
| dma_req | output | 1 | FIFO word available to DMA |
| fifo_rd | input | 1 | DMA read strobe |
| fifo_rdata | output | WORD_W (32) | Oldest FIFO word |

## Verification
The bench builds the block with FIFO_DEPTH of 4 and MAX_EXP of 5. A 32-byte block is then enough to overfill the FIFO and reach the overrun path without a long frame. The same setting brings the upper end of the exponent clamp within a short run, and blocks of 4 and 8 bytes keep the multi-block, CRC-error and end-bit-error cases to a few hundred cycles each.

// File: rtl/sdrx_pkg.sv
package sdrx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_WAIT,
      RX_DATA,
      RX_CRC,
      RX_ENDB,
      RX_DONE
   } rx_state_e;

   localparam int FLG_BLK = 0;
   localparam int FLG_END = 1;
   localparam int FLG_CRC = 2;
   localparam int FLG_OVR = 3;
   localparam int FLG_N   = 4;

   localparam logic [15:0] CRC_POLY = 16'h1021;

   // one serial step of the CRC16 register
   function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
      logic fb;
      fb = c[15] ^ b;
      return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
   endfunction

endpackage

// File: rtl/sdrx_crc16.sv
module sdrx_crc16 (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        adv,
   input  logic        bit_in,
   output logic [15:0] crc_out
);
   import sdrx_pkg::*;

   logic [15:0] crc_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) crc_q <= '0;
      else if (adv)      crc_q <= crc16_step(crc_q, bit_in);
   end

   assign crc_out = crc_q;

endmodule

// File: rtl/sdrx_packer.sv
module sdrx_packer #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              byte_vld,
   input  logic [7:0]        byte_in,
   output logic              word_vld,
   output logic [WORD_W-1:0] word_out
);
   localparam int BPW   = WORD_W / 8;
   localparam int IDX_W = (BPW > 1) ? $clog2(BPW) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(BPW - 1);

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)  idx_q <= '0;
      else if (byte_vld)  idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
   end

   assign word_vld = byte_vld && (idx_q == LAST);

   for (genvar g = 0; g < BPW; g++) begin : g_lane
      if (g == BPW - 1) begin : g_top
         assign word_out[g*8 +: 8] = byte_in;
      end else begin : g_held
         logic [7:0] lane_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                                lane_q <= '0;
            else if (byte_vld && idx_q == IDX_W'(g))   lane_q <= byte_in;
         end
         assign word_out[g*8 +: 8] = lane_q;
      end
   end

endmodule

// File: rtl/sdrx_fifo.sv
module sdrx_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

   initial begin
      if (DEPTH < 2 || (1 << AW) != DEPTH) $error("sdrx_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [AW:0]   count;

   assign full  = (count == FULL_CNT);
   assign empty = (count == '0);
   assign rdata = mem[rptr];

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) wptr <= wptr + 1'b1;
         if (pop)  rptr <= rptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);
   assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop && empty));

endmodule

// File: rtl/sd_rx_datapath.sv
module sd_rx_datapath #(
   parameter int WORD_W     = 32,
   parameter int FIFO_DEPTH = 8,
   parameter int MAX_EXP    = 11,
   parameter int EXP_W      = 4,
   parameter int LEN_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dat0,
   input  logic              cfg_en,
   input  logic              cfg_dir_rx,
   input  logic              cfg_dma_en,
   input  logic [EXP_W-1:0]  cfg_blk_exp,
   input  logic [LEN_W-1:0]  cfg_data_len,
   input  logic              clr_we,
   input  logic [3:0]        clr_mask,
   output logic [3:0]        status,
   output logic              busy,
   output logic              dma_req,
   input  logic              fifo_rd,
   output logic [WORD_W-1:0] fifo_rdata
);
   import sdrx_pkg::*;

   localparam int MIN_EXP = 2;
   localparam int BCW     = MAX_EXP + 4;

   initial begin
      if (MAX_EXP < MIN_EXP || MAX_EXP >= (1 << EXP_W))
         $error("sd_rx_datapath: MAX_EXP out of range for EXP_W");
      if (WORD_W % 8 != 0 || ((1 << MIN_EXP) % (WORD_W / 8)) != 0)
         $error("sd_rx_datapath: WORD_W must pack whole bytes and divide the smallest block");
   end

   rx_state_e        state;
   logic [BCW-1:0]   bit_cnt;
   logic [LEN_W:0]   byte_cnt;
   logic [6:0]       shreg;
   logic [15:0]      rx_crc;
   logic [15:0]      crc_val;
   logic [EXP_W-1:0] eff_exp;
   logic [BCW-1:0]   blk_bits_m1;
   logic             run_en, last_data, len_reached;
   logic             byte_vld, word_vld, fifo_full, fifo_empty, fifo_push, fifo_pop;
   logic [WORD_W-1:0] word_data;
   logic [FLG_N-1:0] set_vec, clr_vec;

   assign run_en = cfg_en && cfg_dir_rx;

   always_comb begin
      if (cfg_blk_exp < EXP_W'(MIN_EXP))      eff_exp = EXP_W'(MIN_EXP);
      else if (cfg_blk_exp > EXP_W'(MAX_EXP)) eff_exp = EXP_W'(MAX_EXP);
      else                                    eff_exp = cfg_blk_exp;
   end

   assign blk_bits_m1 = (BCW'(8) << eff_exp) - BCW'(1);
   assign last_data   = (bit_cnt == blk_bits_m1);
   assign len_reached = (byte_cnt >= {1'b0, cfg_data_len});

   // bit sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         bit_cnt  <= '0;
         byte_cnt <= '0;
         shreg    <= '0;
         rx_crc   <= '0;
      end else if (!run_en) begin
         state <= RX_IDLE;
      end else begin
         case (state)
            RX_IDLE: begin
               state    <= RX_WAIT;
               byte_cnt <= '0;
            end
            RX_WAIT: if (!dat0) begin
               state   <= RX_DATA;
               bit_cnt <= '0;
            end
            RX_DATA: begin
               shreg <= {shreg[5:0], dat0};
               if (bit_cnt[2:0] == 3'd7) byte_cnt <= byte_cnt + 1'b1;
               if (last_data) begin
                  state   <= RX_CRC;
                  bit_cnt <= '0;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
            RX_CRC: begin
               rx_crc  <= {rx_crc[14:0], dat0};
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == BCW'(15)) state <= RX_ENDB;
            end
            RX_ENDB: state <= len_reached ? RX_DONE : RX_WAIT;
            default: state <= state;
         endcase
      end
   end

   assign busy = (state != RX_IDLE) && (state != RX_DONE);

   sdrx_crc16 u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (state == RX_WAIT),
      .adv     (run_en && state == RX_DATA),
      .bit_in  (dat0),
      .crc_out (crc_val)
   );

   assign byte_vld = run_en && (state == RX_DATA) && (bit_cnt[2:0] == 3'd7);

   sdrx_packer #(.WORD_W(WORD_W)) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (state == RX_IDLE),
      .byte_vld (byte_vld),
      .byte_in  ({shreg, dat0}),
      .word_vld (word_vld),
      .word_out (word_data)
   );

   assign fifo_push = word_vld && !fifo_full;
   assign dma_req   = cfg_dma_en && !fifo_empty;
   assign fifo_pop  = fifo_rd && dma_req;

   sdrx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (fifo_push),
      .wdata (word_data),
      .pop   (fifo_pop),
      .rdata (fifo_rdata),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   // sticky status
   always_comb begin
      set_vec = '0;
      if (run_en && state == RX_ENDB) begin
         set_vec[FLG_BLK] = dat0 && (rx_crc == crc_val);
         set_vec[FLG_CRC] = !(dat0 && (rx_crc == crc_val));
         set_vec[FLG_END] = len_reached;
      end
      set_vec[FLG_OVR] = word_vld && fifo_full;
      clr_vec = clr_we ? clr_mask : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~clr_vec) | set_vec;
   end

   for (genvar f = 0; f < FLG_N; f++) begin : g_sticky
      assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
         (status[f] && !(clr_we && clr_mask[f])) |=> status[f]);
   end

   assert_blk_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[FLG_BLK]) |-> ($past(state == RX_ENDB) && $past(dat0)));
   assert_blk_crc_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !($rose(status[FLG_BLK]) && $rose(status[FLG_CRC])));
   assert_ovr_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[FLG_OVR]) |-> $past(fifo_full));
   assert_idle_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (state == RX_IDLE));

endmodule

// File: tb/sim_sd_rx_datapath.sv
`timescale 1ns/1ps
module sim_sd_rx_datapath;

   localparam int FD = 4;
   localparam int MX = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dat0 = 1'b1;
   logic        cfg_en = 1'b0, cfg_dir_rx = 1'b0, cfg_dma_en = 1'b0;
   logic [3:0]  cfg_blk_exp = 4'd2;
   logic [15:0] cfg_data_len = 16'd0;
   logic        clr_we = 1'b0;
   logic [3:0]  clr_mask = 4'd0;
   logic [3:0]  status;
   logic        busy, dma_req;
   logic        fifo_rd = 1'b0;
   logic [31:0] fifo_rdata;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   sd_rx_datapath #(.FIFO_DEPTH(FD), .MAX_EXP(MX)) u0 (
      .clk(clk), .rst_n(rst_n), .dat0(dat0), .cfg_en(cfg_en), .cfg_dir_rx(cfg_dir_rx),
      .cfg_dma_en(cfg_dma_en), .cfg_blk_exp(cfg_blk_exp), .cfg_data_len(cfg_data_len),
      .clr_we(clr_we), .clr_mask(clr_mask), .status(status), .busy(busy),
      .dma_req(dma_req), .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata)
   );

   typedef struct packed {
      logic [3:0]  exp;
      logic [15:0] len;
      logic [7:0]  seed;
      logic        bad_crc;
      logic        bad_end;
      logic [3:0]  flags;
   } vec_t;

   // flags: bit0 block done, bit1 transfer done, bit2 CRC error, bit3 overrun
   localparam vec_t VECS [4] = '{
      '{4'd2, 16'd4, 8'h11, 1'b0, 1'b0, 4'b0011},
      '{4'd3, 16'd8, 8'hA5, 1'b1, 1'b0, 4'b0110},
      '{4'd2, 16'd4, 8'h3C, 1'b0, 1'b1, 4'b0110},
      '{4'd1, 16'd4, 8'h7E, 1'b0, 1'b0, 4'b0011}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
      return seed + 8'(k * 29);
   endfunction

   function automatic logic [31:0] pat_word(input logic [7:0] seed, input int k);
      return {pat(seed, k + 3), pat(seed, k + 2), pat(seed, k + 1), pat(seed, k)};
   endfunction

   task automatic send_bit(input logic b);
      @(negedge clk);
      dat0 = b;
   endtask

   task automatic idle(input int n);
      repeat (n) send_bit(1'b1);
   endtask

   task automatic send_block(input int bsize, input int k0, input logic [7:0] seed,
                             input logic bad_crc, input logic bad_end);
      logic [15:0] c;
      logic [7:0]  d;
      logic        fb;
      c = '0;
      send_bit(1'b0);
      for (int i = 0; i < bsize; i++) begin
         d = pat(seed, k0 + i);
         for (int j = 7; j >= 0; j--) begin
            fb = c[15] ^ d[j];
            c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
            send_bit(d[j]);
         end
      end
      if (bad_crc) c = c ^ 16'h0001;
      for (int j = 15; j >= 0; j--) send_bit(c[j]);
      send_bit(!bad_end);
      idle(3);
   endtask

   task automatic arm(input logic [3:0] e, input logic [15:0] len, input logic dir, input logic dma);
      @(negedge clk);
      cfg_blk_exp = e; cfg_data_len = len; cfg_dir_rx = dir; cfg_dma_en = dma;
      cfg_en = 1'b1; clr_we = 1'b1; clr_mask = 4'hF;
      @(negedge clk);
      clr_we = 1'b0; clr_mask = 4'h0;
      idle(2);
   endtask

   task automatic disarm();
      @(negedge clk);
      cfg_en = 1'b0;
      idle(2);
   endtask

   task automatic pop_check(input string tag, input logic [31:0] exp);
      @(negedge clk);
      check({tag, " dma_req"}, {31'd0, dma_req}, 32'd1);
      check({tag, " word"}, fifo_rdata, exp);
      fifo_rd = 1'b1;
      @(negedge clk);
      fifo_rd = 1'b0;
   endtask

   task automatic clear_flags(input logic [3:0] m);
      @(negedge clk);
      clr_we = 1'b1; clr_mask = m;
      @(negedge clk);
      clr_we = 1'b0; clr_mask = 4'h0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int e, bsize, nblk;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 status", {28'd0, status}, 32'd0);
      check("R1 busy", {31'd0, busy}, 32'd0);
      check("R1 dma_req", {31'd0, dma_req}, 32'd0);

      // table-driven frames: R3 R4 R5 R6 R9
      for (int v = 0; v < 4; v++) begin
         e = (VECS[v].exp < 2) ? 2 : ((VECS[v].exp > MX) ? MX : int'(VECS[v].exp));
         bsize = 1 << e;
         nblk = (int'(VECS[v].len) + bsize - 1) / bsize;
         arm(VECS[v].exp, VECS[v].len, 1'b1, 1'b1);
         for (int b = 0; b < nblk; b++)
            send_block(bsize, b * bsize, VECS[v].seed,
                       VECS[v].bad_crc && b == nblk - 1, VECS[v].bad_end && b == nblk - 1);
         check($sformatf("R3 R4 R5 R6 R7 status vec%0d", v), {28'd0, status}, {28'd0, VECS[v].flags});
         for (int w = 0; w < nblk * bsize / 4; w++)
            pop_check($sformatf("R6 R9 vec%0d w%0d", v, w), pat_word(VECS[v].seed, 4 * w));
         @(negedge clk);
         check($sformatf("R11 drained vec%0d", v), {31'd0, dma_req}, 32'd0);
         disarm();
      end

      // multi-block transfer: R8 then R7
      arm(4'd2, 16'd10, 1'b1, 1'b1);
      send_block(4, 0, 8'h42, 1'b0, 1'b0);
      check("R8 status after block 1", {28'd0, status}, 32'h1);
      check("R8 busy between blocks", {31'd0, busy}, 32'd1);
      send_block(4, 4, 8'h42, 1'b0, 1'b0);
      send_block(4, 8, 8'h42, 1'b0, 1'b0);
      check("R7 status after block 3", {28'd0, status}, 32'h3);
      check("R7 parked", {31'd0, busy}, 32'd0);
      send_block(4, 12, 8'h42, 1'b0, 1'b0);
      for (int w = 0; w < 3; w++) pop_check("R7 R8 words", pat_word(8'h42, 4 * w));
      @(negedge clk);
      check("R7 extra frame ignored", {31'd0, dma_req}, 32'd0);
      disarm();

      // direction clear: R2
      arm(4'd2, 16'd4, 1'b0, 1'b1);
      send_block(4, 0, 8'h99, 1'b0, 1'b0);
      check("R2 dir status", {28'd0, status}, 32'd0);
      check("R2 dir busy", {31'd0, busy}, 32'd0);
      check("R2 dir fifo", {31'd0, dma_req}, 32'd0);
      disarm();

      // disable mid-block, then a clean block: R2 R9
      arm(4'd3, 16'd8, 1'b1, 1'b1);
      send_bit(1'b0);
      for (int i = 0; i < 20; i++) send_bit(i[0]);
      disarm();
      check("R2 abort busy", {31'd0, busy}, 32'd0);
      arm(4'd2, 16'd4, 1'b1, 1'b1);
      send_block(4, 0, 8'h5A, 1'b0, 1'b0);
      check("R2 after abort status", {28'd0, status}, 32'h3);
      pop_check("R9 after abort", pat_word(8'h5A, 0));
      disarm();

      // DMA enable gating: R11
      arm(4'd2, 16'd4, 1'b1, 1'b0);
      send_block(4, 0, 8'hC3, 1'b0, 1'b0);
      check("R11 dma off req", {31'd0, dma_req}, 32'd0);
      @(negedge clk);
      cfg_dma_en = 1'b1;
      pop_check("R11 dma on", pat_word(8'hC3, 0));
      disarm();

      // overrun: R10, then partial clears: R12
      arm(4'd5, 16'd32, 1'b1, 1'b1);
      send_block(32, 0, 8'h0F, 1'b0, 1'b0);
      check("R10 status", {28'd0, status}, 32'hB);
      for (int w = 0; w < FD; w++) pop_check("R10 kept words", pat_word(8'h0F, 4 * w));
      @(negedge clk);
      check("R10 dropped words", {31'd0, dma_req}, 32'd0);
      clear_flags(4'b0001);
      check("R12 partial clear", {28'd0, status}, 32'hA);
      clear_flags(4'b1010);
      check("R12 full clear", {28'd0, status}, 32'h0);
      disarm();

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule